// File: doc/BRIEF.md
# Mode-Aware 8-Bit GPIO Port Controller

This block is an eight-pin general-purpose I/O port whose pins can be taken over by a bus controller. Software reaches it over a small register bus that has an address, write data, a write strobe, a read strobe and registered read data. The bus exposes three registers:

- a direction register that can only be written;
- an output data register that can be read and written;
- a read-only view of the pin levels.

For each pin the block produces an output value and an output enable for the pad driver.

An operating-mode input picks between the expanded modes (4, 5 and 6) and the single-chip mode (7). In the expanded modes the four middle pins are forced to carry the external strobes, whatever the direction bits say. The three low pins can be claimed one by one by the bus controller for its wait, bus-acknowledge and bus-request signals. The top pin is always an ordinary port pin. The mode also sets the power-on value of the direction register.

The block also handles two reset inputs and two standby inputs:

- A manual reset and software standby both leave the direction register alone.
- Hardware standby sets the registers back to their power-on values and releases every pin.
- In software standby, a control input decides whether the pins held by the bus controller keep driving their last value or float.

Top module: `gpio_port_ctl`

## Requirements
- R1: The bus map is as follows, and read data appears on `bus_rdata` one clock after the read strobe is sampled.
  - The data register is at 0xFF0E and reads back what was last written.
  - A read of the direction register at 0xFE3E returns 0xFF.
  - A read of any address that is not mapped returns 0x00.
- R2: After a power-on reset, the data register is 0x00. The direction register is 0x80 when `mode_sel` is 4, 5 or 6, and 0x00 when `mode_sel` is 7.
- R3: While `hw_stby` is high, every bit of `pin_oe` is 0 and register writes are ignored. Once `hw_stby` falls, the direction register holds its power-on value for the current mode and the data register holds 0x00.
- R4: A cycle with `man_rst` high clears the data register and leaves the direction register unchanged. A write in the same cycle is dropped.
- R5: In the expanded modes, pins 6 to 3 always have their output enable set and output `bc_stb[3:0]`, with bit 3 going to pin 6, whatever the direction bits say.
- R6: In every mode, pin 7 drives data bit 7 with its output enable equal to direction bit 7.
- R7: In the expanded modes, low pin i (where i is 0, 1 or 2) follows the bus controller while `bc_ctl_en[i]` is high. Its output is then `bc_ctl_val[i]` and its enable is `bc_ctl_oe[i]`. While `bc_ctl_en[i]` is low, the pin follows direction and data bit i.
- R8: In mode 7 there are no overrides. `pin_oe` equals the direction register and `pin_out` equals the data register, whatever the bus-controller inputs do.
- R9: In software standby, the pins held by the bus controller follow `stby_keep`.
  - With `stby_keep` high, they keep the value and enable they had on the clock before standby began.
  - With `stby_keep` low, their enables are 0.
  - Port pins keep driving from the registers.
- R10: While `sw_stby` is high, register writes are ignored, so the direction and data registers stay unchanged.
- R11: A read of 0xFFBE returns the levels on `pin_in`, sampled one clock earlier, for every pin whatever its direction. A write to 0xFFBE changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; asserts asynchronously and is released through a synchronizer |
| man_rst | input | 1 | Manual reset, active high, synchronous |
| mode_sel | input | 3 | Operating mode; 7 selects single-chip mode, any other value selects an expanded mode |
| hw_stby | input | 1 | Hardware standby indication |
| sw_stby | input | 1 | Software standby indication |
| stby_keep | input | 1 | In software standby, 1 keeps the bus-controller pins driving and 0 floats them |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| bc_stb | input | 4 | Strobe values for pins 6 to 3 |
| bc_ctl_en | input | 3 | Bus-controller claim for each of pins 2 to 0 |
| bc_ctl_val | input | 3 | Bus-controller output value for pins 2 to 0 |
| bc_ctl_oe | input | 3 | Bus-controller output enable for pins 2 to 0 |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
Two pairs of functions can fall in the same cycle, and the tests provoke each on purpose.

The first pair is a manual reset and a data-register write. The bench raises `man_rst` on the same clock as a write strobe. It then reads the data register back, where it must find 0x00, and checks through `pin_oe` that the direction register kept its value.

The second pair is entry into software standby and a change of the bus-controller strobes. The bench raises `sw_stby` and changes `bc_stb` on the same clock. It then judges `pin_out` against the strobe value from the cycle before, and checks that port pin 7 still drives from its registers.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PIN_N   = 8;   // pins in the port
  localparam int STB_LSB = 3;   // lowest pin carrying a forced strobe
  localparam int STB_N   = 4;   // number of forced strobe pins
  localparam int CTL_N   = 3;   // low pins that the bus controller may claim
  localparam int MODE_W  = 3;
  localparam logic [MODE_W-1:0] MODE_SINGLE = 3'd7;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_DAT,
    SEL_PIN
  } reg_sel_e;

  // Power-on direction value: only the top pin starts as an output, and only in expanded modes.
  function automatic logic [PIN_N-1:0] dir_default(input logic expanded);
    return {expanded, {(PIN_N-1){1'b0}}};
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFE3E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'hFF0E,
  parameter logic [ADDR_W-1:0] PIN_ADDR = 16'hFFBE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expanded,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              man_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_N-1:0]  wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PIN_N-1:0]  pin_in,
  output logic [PIN_N-1:0]  rdata,
  output logic [PIN_N-1:0]  dir_eff,
  output logic [PIN_N-1:0]  dat_out
);
  reg_sel_e         sel;
  logic             wr_ok;
  logic [PIN_N-1:0] dir_q, dir_d;
  logic             dflt_q, dflt_d;
  logic [PIN_N-1:0] dat_q, dat_d;
  logic             dir_en, dat_en;
  logic [PIN_N-1:0] pin_q;
  logic [PIN_N-1:0] rd_mux;
  logic [PIN_N-1:0] rdata_q;

  // Address decode
  always_comb begin
    if (addr == DIR_ADDR)      sel = SEL_DIR;
    else if (addr == DAT_ADDR) sel = SEL_DAT;
    else if (addr == PIN_ADDR) sel = SEL_PIN;
    else                       sel = SEL_NONE;
  end

  // Writes are dropped in either standby and in a manual-reset cycle.
  assign wr_ok = wr_en & ~hw_stby & ~sw_stby & ~man_rst;

  // Next state. The direction register keeps a "still at default" flag, so that its
  // power-on value can follow the mode input without a non-constant asynchronous reset.
  always_comb begin
    dir_d  = dir_q;
    dflt_d = dflt_q;
    dat_d  = dat_q;
    dir_en = 1'b0;
    dat_en = 1'b0;
    if (hw_stby) begin
      dflt_d = 1'b1;
      dir_en = 1'b1;
      dat_d  = '0;
      dat_en = 1'b1;
    end else if (man_rst) begin
      dat_d  = '0;
      dat_en = 1'b1;
    end else if (wr_ok) begin
      unique case (sel)
        SEL_DIR: begin
          dir_d  = wdata;
          dflt_d = 1'b0;
          dir_en = 1'b1;
        end
        SEL_DAT: begin
          dat_d  = wdata;
          dat_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dflt_q <= 1'b1;
    end else if (dir_en) begin
      dir_q  <= dir_d;
      dflt_q <= dflt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= dat_d;
  end

  // Pin levels are sampled every clock and carry no reset value.
  always_ff @(posedge clk) begin
    pin_q <= pin_in;
  end

  assign dir_eff = dflt_q ? dir_default(expanded) : dir_q;
  assign dat_out = dat_q;

  // Read data
  always_comb begin
    unique case (sel)
      SEL_DIR: rd_mux = '1;
      SEL_DAT: rd_mux = dat_q;
      SEL_PIN: rd_mux = pin_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
(
  input  logic             expanded,
  input  logic [PIN_N-1:0] dir,
  input  logic [PIN_N-1:0] dat,
  input  logic [STB_N-1:0] stb_val,
  input  logic [CTL_N-1:0] ctl_en,
  input  logic [CTL_N-1:0] ctl_val,
  input  logic [CTL_N-1:0] ctl_oe,
  output logic [PIN_N-1:0] val,
  output logic [PIN_N-1:0] oe,
  output logic [PIN_N-1:0] bc_mask
);
  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    if (i >= STB_LSB && i < STB_LSB + STB_N) begin : g_stb
      // Forced strobe pins: direction bits are ignored in expanded modes.
      assign bc_mask[i] = expanded;
      assign val[i]     = expanded ? stb_val[i-STB_LSB] : dat[i];
      assign oe[i]      = expanded | dir[i];
    end else if (i < CTL_N) begin : g_ctl
      // Low pins that the bus controller can claim one by one.
      logic claim;
      assign claim      = expanded & ctl_en[i];
      assign bc_mask[i] = claim;
      assign val[i]     = claim ? ctl_val[i] : dat[i];
      assign oe[i]      = claim ? ctl_oe[i]  : dir[i];
    end else begin : g_port
      // Plain port pin in every mode.
      assign bc_mask[i] = 1'b0;
      assign val[i]     = dat[i];
      assign oe[i]      = dir[i];
    end
  end
endmodule

// File: rtl/gpio_stby_hold.sv
module gpio_stby_hold
  import gpio_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             keep,
  input  logic [PIN_N-1:0] live_val,
  input  logic [PIN_N-1:0] live_oe,
  input  logic [PIN_N-1:0] live_mask,
  output logic [PIN_N-1:0] pin_out,
  output logic [PIN_N-1:0] pin_oe
);
  logic             cap_en;
  logic [PIN_N-1:0] hv_q, ho_q, hm_q;

  // Capture the live drive on every clock outside software standby.
  assign cap_en = ~sw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= '0;
      ho_q <= '0;
      hm_q <= '0;
    end else if (cap_en) begin
      hv_q <= live_val;
      ho_q <= live_oe;
      hm_q <= live_mask;
    end
  end

  for (genvar i = 0; i < PIN_N; i++) begin : g_out
    always_comb begin
      if (hw_stby) begin
        pin_out[i] = 1'b0;
        pin_oe[i]  = 1'b0;
      end else if (sw_stby && hm_q[i]) begin
        pin_out[i] = hv_q[i];
        pin_oe[i]  = keep & ho_q[i];
      end else begin
        pin_out[i] = live_val[i];
        pin_oe[i]  = live_oe[i];
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFE3E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'hFF0E,
  parameter logic [ADDR_W-1:0] PIN_ADDR = 16'hFFBE,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              man_rst,
  input  logic [2:0]        mode_sel,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              stby_keep,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [3:0]        bc_stb,
  input  logic [2:0]        bc_ctl_en,
  input  logic [2:0]        bc_ctl_val,
  input  logic [2:0]        bc_ctl_oe,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pin_out,
  output logic [7:0]        pin_oe
);
  logic             rst_int_n;
  logic             expanded;
  logic [PIN_N-1:0] dir_eff, dat_q;
  logic [PIN_N-1:0] live_val, live_oe, live_mask;

  assign expanded = (mode_sel != MODE_SINGLE);

  gpio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (rst_int_n)
  );

  gpio_regfile #(
    .ADDR_W   (ADDR_W),
    .DIR_ADDR (DIR_ADDR),
    .DAT_ADDR (DAT_ADDR),
    .PIN_ADDR (PIN_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .expanded (expanded),
    .hw_stby  (hw_stby),
    .sw_stby  (sw_stby),
    .man_rst  (man_rst),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .pin_in   (pin_in),
    .rdata    (bus_rdata),
    .dir_eff  (dir_eff),
    .dat_out  (dat_q)
  );

  gpio_pin_mux u_mux (
    .expanded (expanded),
    .dir      (dir_eff),
    .dat      (dat_q),
    .stb_val  (bc_stb),
    .ctl_en   (bc_ctl_en),
    .ctl_val  (bc_ctl_val),
    .ctl_oe   (bc_ctl_oe),
    .val      (live_val),
    .oe       (live_oe),
    .bc_mask  (live_mask)
  );

  gpio_stby_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .keep      (stby_keep),
    .live_val  (live_val),
    .live_oe   (live_oe),
    .live_mask (live_mask),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFE3E
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_sel,
  input logic              man_rst,
  input logic              hw_stby,
  input logic              sw_stby,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic [3:0]        bc_stb,
  input logic [7:0]        pin_out,
  input logic [7:0]        pin_oe,
  input logic [7:0]        dir_eff,
  input logic [7:0]        dat_q
);
  // R1: the write-only direction register reads as all ones on the next clock.
  assert_dir_read_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DIR_ADDR) |=> bus_rdata == 8'hFF);

  // R3: no pin is driven in hardware standby.
  assert_hw_stby_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> pin_oe == 8'h00);

  // R4: a manual reset clears the data register.
  assert_man_rst_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (man_rst && !hw_stby) |=> dat_q == 8'h00);

  // R4: a manual reset keeps the direction register.
  assert_man_rst_keep_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (man_rst && !hw_stby) |=> ($stable(dir_eff) || !$stable(mode_sel)));

  // R5: strobe pins are forced outputs in the expanded modes.
  assert_strobe_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 3'd7 && !hw_stby && !sw_stby) |-> (pin_oe[6:3] == 4'hF && pin_out[6:3] == bc_stb));

  // R8: in single-chip mode the pins mirror the registers.
  assert_single_mode_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd7 && !hw_stby && !sw_stby) |-> (pin_oe == dir_eff && pin_out == dat_q));

  // R10: the data register is frozen in software standby.
  assert_sw_stby_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby && !man_rst) |=> $stable(dat_q));
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .mode_sel  (mode_sel),
  .man_rst   (man_rst),
  .hw_stby   (hw_stby),
  .sw_stby   (sw_stby),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .bc_stb    (bc_stb),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .dir_eff   (dir_eff),
  .dat_q     (dat_q)
);

// File: tb/gpio_port_ctl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_DIR = 16'hFE3E;
  localparam logic [15:0] A_DAT = 16'hFF0E;
  localparam logic [15:0] A_PIN = 16'hFFBE;
  localparam logic [15:0] A_NONE = 16'h1234;

  logic        clk = 1'b0;
  logic        por_n;
  logic        man_rst;
  logic [2:0]  mode_sel;
  logic        hw_stby, sw_stby, stby_keep;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_rdata;
  logic [3:0]  bc_stb;
  logic [2:0]  bc_ctl_en, bc_ctl_val, bc_ctl_oe;
  logic [7:0]  pin_in, pin_out, pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctl u_gpio_port_ctl (
    .clk(clk), .por_n(por_n), .man_rst(man_rst), .mode_sel(mode_sel),
    .hw_stby(hw_stby), .sw_stby(sw_stby), .stby_keep(stby_keep),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bc_stb(bc_stb), .bc_ctl_en(bc_ctl_en),
    .bc_ctl_val(bc_ctl_val), .bc_ctl_oe(bc_ctl_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] mode);
    @(negedge clk);
    por_n = 1'b0; mode_sel = mode; man_rst = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0;
    stby_keep = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = A_NONE; bus_wdata = 8'h00;
    bc_stb = 4'h0; bc_ctl_en = 3'b000; bc_ctl_val = 3'b000; bc_ctl_oe = 3'b000; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_NONE;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = A_NONE;
    d = bus_rdata;
  endtask

  task automatic t_reset_expanded;
    logic [7:0] d;
    do_reset(3'd4);
    check8("R2", "expanded reset oe", pin_oe, 8'hF8);
    check8("R2", "expanded reset out", pin_out, 8'h00);
    rd(A_DAT, d);
    check8("R2", "data after reset", d, 8'h00);
    rd(A_DIR, d);
    check8("R1", "direction reads ones", d, 8'hFF);
    rd(A_NONE, d);
    check8("R1", "unmapped read", d, 8'h00);
  endtask

  task automatic t_single_mode;
    logic [7:0] d;
    do_reset(3'd7);
    check8("R2", "single-mode reset oe", pin_oe, 8'h00);
    wr(A_DIR, 8'h5A);
    wr(A_DAT, 8'hC3);
    bc_stb = 4'hF; bc_ctl_en = 3'b111; bc_ctl_val = 3'b111; bc_ctl_oe = 3'b111;
    @(negedge clk);
    check8("R8", "single-mode oe", pin_oe, 8'h5A);
    check8("R8", "single-mode out", pin_out, 8'hC3);
    rd(A_DAT, d);
    check8("R1", "data readback", d, 8'hC3);
  endtask

  task automatic t_expanded_pins;
    do_reset(3'd5);
    bc_stb = 4'b1010;
    wr(A_DIR, 8'h00);
    check8("R5", "strobe oe with dir 0", pin_oe, 8'h78);
    check8("R5", "strobe out", pin_out, 8'h50);
    wr(A_DIR, 8'hFF);
    wr(A_DAT, 8'h80);
    check8("R6", "pin7 output oe", pin_oe, 8'hFF);
    check8("R6", "pin7 output value", pin_out, 8'hD0);
    bc_ctl_en = 3'b101; bc_ctl_val = 3'b001; bc_ctl_oe = 3'b100;
    @(negedge clk);
    check8("R7", "low pin claim oe", pin_oe, 8'hFE);
    check8("R7", "low pin claim out", pin_out, 8'hD1);
    bc_ctl_en = 3'b000;
    wr(A_DIR, 8'h7F);
    check8("R6", "pin7 input when dir 0", pin_oe, 8'h7F);
  endtask

  task automatic t_pin_state;
    logic [7:0] d;
    do_reset(3'd7);
    wr(A_DIR, 8'h0F);
    wr(A_DAT, 8'h66);
    pin_in = 8'h3C;
    repeat (2) @(negedge clk);
    rd(A_PIN, d);
    check8("R11", "pin levels", d, 8'h3C);
    wr(A_PIN, 8'hAA);
    rd(A_DAT, d);
    check8("R11", "pin write ignored (data)", d, 8'h66);
    check8("R11", "pin write ignored (dir)", pin_oe, 8'h0F);
  endtask

  task automatic t_manual_reset;
    logic [7:0] d;
    do_reset(3'd7);
    wr(A_DIR, 8'h3C);
    wr(A_DAT, 8'hFF);
    man_rst = 1'b1;
    wr(A_DAT, 8'h11);
    man_rst = 1'b0;
    rd(A_DAT, d);
    check8("R4", "data cleared despite write", d, 8'h00);
    check8("R4", "direction retained", pin_oe, 8'h3C);
  endtask

  task automatic t_hw_standby;
    logic [7:0] d;
    do_reset(3'd4);
    wr(A_DIR, 8'h07);
    wr(A_DAT, 8'h55);
    hw_stby = 1'b1;
    @(negedge clk);
    check8("R3", "oe in hw standby", pin_oe, 8'h00);
    wr(A_DAT, 8'hAA);
    hw_stby = 1'b0;
    @(negedge clk);
    rd(A_DAT, d);
    check8("R3", "data after hw standby", d, 8'h00);
    check8("R3", "direction back to default", pin_oe, 8'hF8);
  endtask

  task automatic t_sw_standby;
    logic [7:0] d;
    do_reset(3'd6);
    wr(A_DAT, 8'h80);
    bc_stb = 4'b0110;
    @(negedge clk);
    sw_stby = 1'b1; stby_keep = 1'b1; bc_stb = 4'b1001;
    @(negedge clk);
    check8("R9", "held strobe out", pin_out, 8'hB0);
    check8("R9", "held strobe oe", pin_oe, 8'hF8);
    stby_keep = 1'b0;
    @(negedge clk);
    check8("R9", "floated strobes, port kept", pin_oe, 8'h80);
    wr(A_DAT, 8'h00);
    wr(A_DIR, 8'h00);
    sw_stby = 1'b0;
    @(negedge clk);
    rd(A_DAT, d);
    check8("R10", "data frozen in sw standby", d, 8'h80);
    check8("R10", "direction frozen in sw standby", pin_oe, 8'hF8);
  endtask

  initial begin
    t_reset_expanded();
    t_single_mode();
    t_expanded_pins();
    t_pin_state();
    t_manual_reset();
    t_hw_standby();
    t_sw_standby();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule